// File: doc/BRIEF.md
# I2C Real-Time-Clock Transaction Monitor

This block sits behind an I2C bus decoder and watches the stream of decoded bus events: start, repeated start, stop, address-write, address-read, data-write and data-read. Each event carries one byte. The monitor follows complete transactions aimed at a real-time-clock slave at address 0x68 and keeps track of the slave's register pointer across multi-byte transfers. It captures the time-keeping fields as they pass on the bus, in either direction. At stop it presents a completed date/time record, marked as a read or a write.

Transactions addressed to any other slave raise a one-cycle warning that carries the offending address. Bytes that fall in the slave's general-purpose RAM area are reported raw, one pulse for each byte. The block does no bit-level bus decoding and keeps no time of its own. It only reflects what it observes on the bus.

Top module: `rtc_i2c_monitor`

## Requirements
- R1: Event encoding on evt_kind_i is 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write, 6 data-read. Events with evt_valid_i low are ignored. In the idle state every event except start is ignored. A start records stamp_i, and that value is presented on rec_stamp_o with the record that closes the transaction.
- R2: The first address event after a start must be an address-write with byte 0x68. Any other byte raises warn_o for one cycle, with warn_addr_o equal to that byte, and the monitor returns to idle.
- R3: After the slave address, the first data-write loads the register pointer with its byte. Each later data-write is stored at the pointer.
- R4: A repeated start during the write phase selects the read path. An address-read to 0x68 then enables data-read capture at the pointer. Any other address-read byte raises warn_o with that byte and returns to idle.
- R5: The pointer advances by one after every stored or captured data byte. When the pointer is at 0x3F or above, the next advance sets it to 0x00.
- R6: Pointer values 0 to 7 address clock registers. The fields are: 0 seconds from bits 6:0, 1 minutes from bits 6:0, 3 day of week from bits 2:0, 4 date from bits 5:0, 5 month from bits 4:0, 6 year from bits 7:0. Every field except day of week is BCD and is converted as low nibble plus ten times high nibble. Pointer values 8 and up pulse ram_valid_o for one cycle with the pointer on ram_addr_o and the raw byte on ram_data_o.
- R7: For register 2 (hours), bit 6 set selects 12-hour mode (mode12_o=1). In that mode pm_o follows bit 5 and hour_o is the BCD value of bits 4:0. With bit 6 clear, hour_o is the BCD value of bits 5:0 and pm_o is 0.
- R8: For register 7, bits 1:0 select the square-wave rate shown on sqw_hz_o: 00 gives 1, 01 gives 4096, 10 gives 8192, 11 gives 32768.
- R9: A stop in the write phase pulses rec_valid_o for one cycle with rec_read_o=0. A stop in the read phase pulses it with rec_read_o=1. A stop in any state returns the monitor to idle, and a stop outside the two phases produces no record.
- R10: After reset, all outputs are zero except sqw_hz_o, which reads 1. Fields hold their last captured value until they are overwritten or the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe |
| evt_kind_i | input | 3 | Event kind code |
| evt_byte_i | input | 8 | Byte carried by the event |
| stamp_i | input | STAMP_W | Time stamp sampled at start |
| rec_valid_o | output | 1 | Record complete pulse |
| rec_read_o | output | 1 | Record came from a read transaction |
| rec_stamp_o | output | STAMP_W | Stamp of the transaction start |
| sec_o | output | 7 | Seconds, binary |
| min_o | output | 7 | Minutes, binary |
| hour_o | output | 7 | Hour, binary |
| mode12_o | output | 1 | 12-hour mode |
| pm_o | output | 1 | PM flag in 12-hour mode |
| dow_o | output | 3 | Day of week |
| date_o | output | 7 | Day of month, binary |
| month_o | output | 7 | Month, binary |
| year_o | output | 8 | Year, binary |
| sqw_hz_o | output | 16 | Square-wave rate in Hz |
| ram_valid_o | output | 1 | RAM byte pulse |
| ram_addr_o | output | 8 | RAM byte pointer |
| ram_data_o | output | 8 | RAM byte value |
| warn_o | output | 1 | Foreign slave address pulse |
| warn_addr_o | output | 8 | Foreign address byte |

## Verification
The hardest case to reach from the ports is the pointer wrap. The pointer cannot be observed directly. Its value shows only through which field or RAM address the next byte lands in. The stimulus therefore loads the pointer with 0x3F, and separately with 0x50, writes one RAM byte and then one more byte, and checks that the second byte lands in seconds. A foreign address on the read path is reached only after a valid write prefix and a repeated start. The read-path warning is checked that way, followed by a data-read that must leave the control field unchanged.

// File: rtl/rtcmon_pkg.sv
package rtcmon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6,
    EV_NONE    = 3'd7
  } evt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SLV,
    ST_WAIT_REG,
    ST_WR,
    ST_WAIT_RD_ADDR,
    ST_RD
  } state_e;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return {4'd0, b[3:0]} + ({4'd0, b[7:4]} * 8'd10);
  endfunction

endpackage

// File: rtl/rtcmon_seq.sv
module rtcmon_seq
  import rtcmon_pkg::*;
#(
  parameter logic [7:0] SLAVE_ADDR = 8'h68
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_valid_i,
  input  logic [2:0] evt_kind_i,
  input  logic [7:0] evt_byte_i,
  output logic       start_fire_o,
  output logic       ptr_load_o,
  output logic       data_stb_o,
  output logic       rec_fire_o,
  output logic       rec_read_o,
  output logic       warn_fire_o
);

  state_e st_q, st_d;
  evt_e   ev;
  logic   addr_ok;

  assign ev      = evt_e'(evt_kind_i);
  assign addr_ok = (evt_byte_i == SLAVE_ADDR);

  always_comb begin
    st_d         = st_q;
    start_fire_o = 1'b0;
    ptr_load_o   = 1'b0;
    data_stb_o   = 1'b0;
    rec_fire_o   = 1'b0;
    rec_read_o   = 1'b0;
    warn_fire_o  = 1'b0;
    if (evt_valid_i) begin
      unique case (st_q)
        ST_IDLE: if (ev == EV_START) begin
          st_d         = ST_WAIT_SLV;
          start_fire_o = 1'b1;
        end
        ST_WAIT_SLV: if (ev == EV_ADDR_WR) begin
          if (addr_ok) st_d = ST_WAIT_REG;
          else begin
            st_d        = ST_IDLE;
            warn_fire_o = 1'b1;
          end
        end
        ST_WAIT_REG: if (ev == EV_DATA_WR) begin
          ptr_load_o = 1'b1;
          st_d       = ST_WR;
        end
        ST_WR: begin
          if (ev == EV_RSTART) st_d = ST_WAIT_RD_ADDR;
          if (ev == EV_DATA_WR) data_stb_o = 1'b1;
          if (ev == EV_STOP) rec_fire_o = 1'b1;
        end
        ST_WAIT_RD_ADDR: if (ev == EV_ADDR_RD) begin
          if (addr_ok) st_d = ST_RD;
          else begin
            st_d        = ST_IDLE;
            warn_fire_o = 1'b1;
          end
        end
        ST_RD: begin
          if (ev == EV_DATA_RD) data_stb_o = 1'b1;
          if (ev == EV_STOP) begin
            rec_fire_o = 1'b1;
            rec_read_o = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      // stop always ends the transaction
      if (ev == EV_STOP) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(evt_valid_i && ev == EV_START)) |=> st_q == ST_IDLE);

  assert_warn_to_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_fire_o |=> st_q == ST_IDLE);

  assert_read_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && evt_valid_i && ev == EV_RSTART) |=> st_q == ST_WAIT_RD_ADDR);

  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && ev == EV_STOP) |=> st_q == ST_IDLE);

endmodule

// File: rtl/rtcmon_ptr.sv
module rtcmon_ptr #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned LAST  = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] LastVal = PTR_W'(LAST);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= (ptr_q >= LastVal) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q >= LastVal) |=> ptr_q == '0);

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q < LastVal) |=> ptr_q == $past(ptr_q) + 1'b1);

  assert_ptr_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_q == $past(load_val_i));

endmodule

// File: rtl/rtcmon_regs.sv
module rtcmon_regs
  import rtcmon_pkg::*;
#(
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned CLK_REGS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_stb_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       byte_i,
  input  logic             rec_fire_i,
  input  logic             rec_read_i,
  output logic             rec_valid_o,
  output logic             rec_read_o,
  output logic [6:0]       sec_o,
  output logic [6:0]       min_o,
  output logic [6:0]       hour_o,
  output logic             mode12_o,
  output logic             pm_o,
  output logic [2:0]       dow_o,
  output logic [6:0]       date_o,
  output logic [6:0]       month_o,
  output logic [7:0]       year_o,
  output logic [15:0]      sqw_hz_o,
  output logic             ram_valid_o,
  output logic [PTR_W-1:0] ram_addr_o,
  output logic [7:0]       ram_data_o
);

  localparam int unsigned SelW = $clog2(CLK_REGS);

  logic            is_clk;
  logic [SelW-1:0] sel;
  logic [1:0]      rate_q;
  logic [7:0]      b_sec, b_min, b_h12, b_h24, b_date, b_mon, b_yr;

  assign is_clk = (ptr_i < PTR_W'(CLK_REGS));
  assign sel    = ptr_i[SelW-1:0];

  assign b_sec  = bcd_to_bin({1'b0, byte_i[6:0]});
  assign b_min  = bcd_to_bin({1'b0, byte_i[6:0]});
  assign b_h12  = bcd_to_bin({3'b0, byte_i[4:0]});
  assign b_h24  = bcd_to_bin({2'b0, byte_i[5:0]});
  assign b_date = bcd_to_bin({2'b0, byte_i[5:0]});
  assign b_mon  = bcd_to_bin({3'b0, byte_i[4:0]});
  assign b_yr   = bcd_to_bin(byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o       <= '0;
      min_o       <= '0;
      hour_o      <= '0;
      mode12_o    <= 1'b0;
      pm_o        <= 1'b0;
      dow_o       <= '0;
      date_o      <= '0;
      month_o     <= '0;
      year_o      <= '0;
      rate_q      <= '0;
      ram_valid_o <= 1'b0;
      ram_addr_o  <= '0;
      ram_data_o  <= '0;
      rec_valid_o <= 1'b0;
      rec_read_o  <= 1'b0;
    end else begin
      ram_valid_o <= 1'b0;
      rec_valid_o <= 1'b0;
      if (data_stb_i) begin
        if (is_clk) begin
          unique case (sel)
            3'd0: sec_o <= b_sec[6:0];
            3'd1: min_o <= b_min[6:0];
            3'd2: begin
              mode12_o <= byte_i[6];
              pm_o     <= byte_i[6] & byte_i[5];
              hour_o   <= byte_i[6] ? b_h12[6:0] : b_h24[6:0];
            end
            3'd3: dow_o   <= byte_i[2:0];
            3'd4: date_o  <= b_date[6:0];
            3'd5: month_o <= b_mon[6:0];
            3'd6: year_o  <= b_yr;
            default: rate_q <= byte_i[1:0];
          endcase
        end else begin
          ram_valid_o <= 1'b1;
          ram_addr_o  <= ptr_i;
          ram_data_o  <= byte_i;
        end
      end
      if (rec_fire_i) begin
        rec_valid_o <= 1'b1;
        rec_read_o  <= rec_read_i;
      end
    end
  end

  always_comb begin
    unique case (rate_q)
      2'b00: sqw_hz_o = 16'd1;
      2'b01: sqw_hz_o = 16'd4096;
      2'b10: sqw_hz_o = 16'd8192;
      default: sqw_hz_o = 16'd32768;
    endcase
  end

  assert_hour12_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_stb_i && ptr_i == PTR_W'(2) && byte_i[6]) |=> (mode12_o && pm_o == $past(byte_i[5])));

  assert_hour24_pm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_stb_i && ptr_i == PTR_W'(2) && !byte_i[6]) |=> (!mode12_o && !pm_o));

  assert_ram_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_stb_i && !is_clk) |=> (ram_valid_o && ram_data_o == $past(byte_i)));

  assert_rec_alone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !ram_valid_o);

endmodule

// File: rtl/rtc_i2c_monitor.sv
module rtc_i2c_monitor #(
  parameter int unsigned STAMP_W    = 16,
  parameter logic [7:0]  SLAVE_ADDR = 8'h68,
  parameter int unsigned LAST_REG   = 63,
  parameter int unsigned CLK_REGS   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [2:0]         evt_kind_i,
  input  logic [7:0]         evt_byte_i,
  input  logic [STAMP_W-1:0] stamp_i,
  output logic               rec_valid_o,
  output logic               rec_read_o,
  output logic [STAMP_W-1:0] rec_stamp_o,
  output logic [6:0]         sec_o,
  output logic [6:0]         min_o,
  output logic [6:0]         hour_o,
  output logic               mode12_o,
  output logic               pm_o,
  output logic [2:0]         dow_o,
  output logic [6:0]         date_o,
  output logic [6:0]         month_o,
  output logic [7:0]         year_o,
  output logic [15:0]        sqw_hz_o,
  output logic               ram_valid_o,
  output logic [7:0]         ram_addr_o,
  output logic [7:0]         ram_data_o,
  output logic               warn_o,
  output logic [7:0]         warn_addr_o
);

  localparam int unsigned PtrW = 8;

  logic            start_fire, ptr_load, data_stb, rec_fire, rec_read, warn_fire;
  logic [PtrW-1:0] ptr;
  logic [STAMP_W-1:0] stamp_q;

  rtcmon_seq #(.SLAVE_ADDR(SLAVE_ADDR)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_valid_i  (evt_valid_i),
    .evt_kind_i   (evt_kind_i),
    .evt_byte_i   (evt_byte_i),
    .start_fire_o (start_fire),
    .ptr_load_o   (ptr_load),
    .data_stb_o   (data_stb),
    .rec_fire_o   (rec_fire),
    .rec_read_o   (rec_read),
    .warn_fire_o  (warn_fire)
  );

  rtcmon_ptr #(.PTR_W(PtrW), .LAST(LAST_REG)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .inc_i      (data_stb),
    .load_val_i (evt_byte_i),
    .ptr_o      (ptr)
  );

  rtcmon_regs #(.PTR_W(PtrW), .CLK_REGS(CLK_REGS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_stb_i  (data_stb),
    .ptr_i       (ptr),
    .byte_i      (evt_byte_i),
    .rec_fire_i  (rec_fire),
    .rec_read_i  (rec_read),
    .rec_valid_o (rec_valid_o),
    .rec_read_o  (rec_read_o),
    .sec_o       (sec_o),
    .min_o       (min_o),
    .hour_o      (hour_o),
    .mode12_o    (mode12_o),
    .pm_o        (pm_o),
    .dow_o       (dow_o),
    .date_o      (date_o),
    .month_o     (month_o),
    .year_o      (year_o),
    .sqw_hz_o    (sqw_hz_o),
    .ram_valid_o (ram_valid_o),
    .ram_addr_o  (ram_addr_o),
    .ram_data_o  (ram_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q     <= '0;
      warn_o      <= 1'b0;
      warn_addr_o <= '0;
    end else begin
      warn_o <= warn_fire;
      if (start_fire) stamp_q <= stamp_i;
      if (warn_fire)  warn_addr_o <= evt_byte_i;
    end
  end

  assign rec_stamp_o = stamp_q;

  assert_warn_foreign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> warn_addr_o != SLAVE_ADDR);

  assert_warn_no_rec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> !rec_valid_o);

endmodule

// File: tb/rtc_i2c_monitor_tb.sv
module rtc_i2c_monitor_tb;

  localparam int CLK_PERIOD = 10;

  // kinds
  localparam logic [2:0] K_S = 3'd0, K_RS = 3'd1, K_P = 3'd2, K_AW = 3'd3,
                         K_AR = 3'd4, K_DW = 3'd5, K_DR = 3'd6, K_NO = 3'd7;
  // checks
  localparam logic [3:0] C_NONE = 4'd0, C_SEC = 4'd1, C_MIN = 4'd2, C_HR = 4'd3,
                         C_MP = 4'd4, C_DOW = 4'd5, C_DATE = 4'd6, C_MON = 4'd7,
                         C_YR = 4'd8, C_SQW = 4'd9, C_RAM = 4'd10, C_REC = 4'd11,
                         C_WARN = 4'd12, C_QUIET = 4'd13;

  // {req, kind, byte, check, expected}
  localparam int NV = 77;
  localparam logic [34:0] VEC [NV] = '{
    // write of every clock register: R3 R6 R7 R8
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_QUIET, 16'd0},
    {4'd3, K_DW, 8'h00, C_QUIET, 16'd0},
    {4'd6, K_DW, 8'h45, C_SEC,   16'd45},
    {4'd6, K_DW, 8'h59, C_MIN,   16'd59},
    {4'd7, K_DW, 8'h72, C_HR,    16'd12},
    {4'd7, K_NO, 8'h00, C_MP,    16'd3},
    {4'd6, K_DW, 8'h05, C_DOW,   16'd5},
    {4'd6, K_DW, 8'h31, C_DATE,  16'd31},
    {4'd6, K_DW, 8'h12, C_MON,   16'd12},
    {4'd6, K_DW, 8'h99, C_YR,    16'd99},
    {4'd8, K_DW, 8'h13, C_SQW,   16'd32768},
    {4'd6, K_DW, 8'hA5, C_RAM,   16'hA508},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // read path, 24-hour hours: R4 R7 R9
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h02, C_NONE,  16'd0},
    {4'd4, K_RS, 8'h00, C_QUIET, 16'd0},
    {4'd4, K_AR, 8'h68, C_QUIET, 16'd0},
    {4'd4, K_DR, 8'h23, C_HR,    16'd23},
    {4'd7, K_NO, 8'h00, C_MP,    16'd0},
    {4'd5, K_DR, 8'h06, C_DOW,   16'd6},
    {4'd9, K_P,  8'h00, C_REC,   16'd1},
    // foreign write address: R2
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h50, C_WARN,  16'h50},
    {4'd2, K_DW, 8'h10, C_QUIET, 16'd0},
    {4'd2, K_DW, 8'h11, C_QUIET, 16'd0},
    {4'd9, K_P,  8'h00, C_QUIET, 16'd0},
    // foreign read address: R4
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h07, C_NONE,  16'd0},
    {4'd4, K_RS, 8'h00, C_NONE,  16'd0},
    {4'd4, K_AR, 8'h51, C_WARN,  16'h51},
    {4'd4, K_DR, 8'h00, C_QUIET, 16'd0},
    {4'd4, K_NO, 8'h00, C_SQW,   16'd32768},
    // wrap at 0x3F: R5
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h3F, C_NONE,  16'd0},
    {4'd5, K_DW, 8'h7E, C_RAM,   16'h7E3F},
    {4'd5, K_DW, 8'h30, C_SEC,   16'd30},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // rate 00, then first RAM byte: R8 R6
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h07, C_NONE,  16'd0},
    {4'd8, K_DW, 8'h00, C_SQW,   16'd1},
    {4'd6, K_DW, 8'hC4, C_RAM,   16'hC408},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // rate 01: R8
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h07, C_NONE,  16'd0},
    {4'd8, K_DW, 8'h01, C_SQW,   16'd4096},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // rate 10 via read: R8 R4
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h07, C_NONE,  16'd0},
    {4'd4, K_RS, 8'h00, C_NONE,  16'd0},
    {4'd4, K_AR, 8'h68, C_NONE,  16'd0},
    {4'd8, K_DR, 8'h02, C_SQW,   16'd8192},
    {4'd5, K_DR, 8'h11, C_RAM,   16'h1108},
    {4'd9, K_P,  8'h00, C_REC,   16'd1},
    // 12-hour AM: R7
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h02, C_NONE,  16'd0},
    {4'd7, K_DW, 8'h49, C_HR,    16'd9},
    {4'd7, K_NO, 8'h00, C_MP,    16'd2},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // pointer loaded above 0x3F: R5
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd3, K_DW, 8'h50, C_NONE,  16'd0},
    {4'd6, K_DW, 8'h22, C_RAM,   16'h2250},
    {4'd5, K_DW, 8'h15, C_SEC,   16'd15},
    {4'd9, K_P,  8'h00, C_REC,   16'd0},
    // stop before register address: R9 R1
    {4'd1, K_S,  8'h00, C_NONE,  16'd0},
    {4'd2, K_AW, 8'h68, C_NONE,  16'd0},
    {4'd9, K_P,  8'h00, C_QUIET, 16'd0},
    {4'd1, K_DW, 8'h33, C_QUIET, 16'd0},
    {4'd1, K_NO, 8'h00, C_SEC,   16'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_kind = 3'd0;
  logic [7:0]  evt_byte = 8'd0;
  logic [15:0] stamp = 16'd0;
  logic        rec_valid, rec_read, mode12, pm, ram_valid, warn;
  logic [15:0] rec_stamp, sqw_hz;
  logic [6:0]  sec, min, hour, date, month;
  logic [2:0]  dow;
  logic [7:0]  year, ram_addr, ram_data, warn_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_i2c_monitor u_dut (
    .clk_i (clk), .rst_ni (rst_n), .evt_valid_i (evt_valid), .evt_kind_i (evt_kind),
    .evt_byte_i (evt_byte), .stamp_i (stamp), .rec_valid_o (rec_valid),
    .rec_read_o (rec_read), .rec_stamp_o (rec_stamp), .sec_o (sec), .min_o (min),
    .hour_o (hour), .mode12_o (mode12), .pm_o (pm), .dow_o (dow), .date_o (date),
    .month_o (month), .year_o (year), .sqw_hz_o (sqw_hz), .ram_valid_o (ram_valid),
    .ram_addr_o (ram_addr), .ram_data_o (ram_data), .warn_o (warn),
    .warn_addr_o (warn_addr)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample at next falling edge
  task automatic send(input logic v, input logic [2:0] k, input logic [7:0] b);
    evt_valid = v;
    evt_kind  = k;
    evt_byte  = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [34:0] e);
    logic [3:0]  rq;
    logic [2:0]  k;
    logic [7:0]  b;
    logic [3:0]  c;
    logic [15:0] x;
    {rq, k, b, c, x} = e;
    send(k != K_NO, k, b);
    case (c)
      C_SEC:  check(sec == x[6:0], rq, "seconds", 32'(sec), 32'(x));
      C_MIN:  check(min == x[6:0], rq, "minutes", 32'(min), 32'(x));
      C_HR:   check(hour == x[6:0], rq, "hour", 32'(hour), 32'(x));
      C_MP:   check({mode12, pm} == x[1:0], rq, "mode12/pm", 32'({mode12, pm}), 32'(x));
      C_DOW:  check(dow == x[2:0], rq, "day of week", 32'(dow), 32'(x));
      C_DATE: check(date == x[6:0], rq, "date", 32'(date), 32'(x));
      C_MON:  check(month == x[6:0], rq, "month", 32'(month), 32'(x));
      C_YR:   check(year == x[7:0], rq, "year", 32'(year), 32'(x));
      C_SQW:  check(sqw_hz == x, rq, "sqw rate", 32'(sqw_hz), 32'(x));
      C_RAM:  check(ram_valid && {ram_data, ram_addr} == x, rq, "ram byte",
                    32'({ram_valid, ram_data, ram_addr}), 32'({1'b1, x}));
      C_REC:  check(rec_valid && rec_read == x[0] && !warn, rq, "record",
                    32'({rec_valid, rec_read}), 32'({1'b1, x[0]}));
      C_WARN: check(warn && warn_addr == x[7:0] && !rec_valid, rq, "warning",
                    32'({warn, warn_addr}), 32'({1'b1, x[7:0]}));
      C_QUIET: check(!rec_valid && !warn && !ram_valid, rq, "no output pulse",
                     32'({rec_valid, warn, ram_valid}), 32'd0);
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!rec_valid && !rec_read && rec_stamp == 0 && sec == 0 && min == 0 && hour == 0 &&
          !mode12 && !pm && dow == 0 && date == 0 && month == 0 && year == 0 &&
          !ram_valid && ram_addr == 0 && ram_data == 0 && !warn && warn_addr == 0,
          10, "outputs in reset", 32'({sec, min, hour}), 32'd0);
    check(sqw_hz == 16'd1, 10, "rate in reset", 32'(sqw_hz), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: start stamp presented with record
    stamp = 16'h1234;
    send(1'b1, K_S, 8'h00);
    stamp = 16'h5555;
    send(1'b1, K_AW, 8'h68);
    send(1'b1, K_DW, 8'h00);
    send(1'b1, K_P, 8'h00);
    check(rec_valid && rec_stamp == 16'h1234, 1, "start stamp", 32'(rec_stamp), 32'h1234);

    // R1: events with valid low are ignored
    send(1'b0, K_S, 8'h00);
    send(1'b1, K_AW, 8'h68);
    send(1'b1, K_DW, 8'h00);
    send(1'b1, K_DW, 8'h21);
    check(sec == 7'd15, 1, "invalid start ignored", 32'(sec), 32'd15);
    send(1'b1, K_P, 8'h00);
    check(!rec_valid, 1, "no record without start", 32'(rec_valid), 32'd0);

    // R10: fields hold, then clear on reset
    repeat (4) @(negedge clk);
    check(year == 8'd99 && dow == 3'd6, 10, "fields held", 32'({year, dow}), 32'({8'd99, 3'd6}));
    rst_n = 1'b0;
    @(negedge clk);
    check(sec == 0 && year == 0 && sqw_hz == 16'd1, 10, "mid-run reset",
          32'({sec, year}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule